// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block picks one interrupt to present to a processor out of a set of maskable request lines and one non-maskable line. Each maskable source carries an enable bit and a level bit. The processor's two mask flags, `mask_i` and `mask_ui`, give three masking states. With both flags clear, everything is open. With only `mask_i` set, only level-1 sources and the non-maskable line get through. With both flags set, only the non-maskable line gets through. Setting a source's level bit also moves that source ahead of every level-0 source in priority.

The winner is registered and held on `pend` and `pend_id` until the processor strobes `ack`. While a grant is held, `next_i` and `next_ui` carry the mask values the processor should load when it takes that grant. When nothing is held, they mirror the current masks. The level bits live in a small bank of registers written through an address/data port. Requests arrive already synchronised.

Top module: `irq_arb`

## Requirements
- R1: After reset, `pend` is 0 and every level bit is 0, so all sources behave as level 0.
- R2: A maskable source whose `en` bit is 0 is never granted, whatever its request, level and the masks.
- R3: A level-0 source can be granted only while `mask_i` is 0; `mask_ui` alone does not block it.
- R4: A level-1 source can be granted while `mask_i` or `mask_ui` is 0, and is blocked only when both are 1.
- R5: Priority order is the non-maskable source first, then level-1 sources, then level-0 sources. Within a level, the lower source index wins. `pend_id` gives the source index, and the value N_SRC (8 by default) means the non-maskable source.
- R6: If `pend` is 0 at a rising clock edge and some source is eligible, the winner appears on `pend`/`pend_id` after that edge. A held grant stays unchanged, even if its request drops or a higher-priority one arrives, until `ack` is 1 at an edge. After that edge `pend` is 0 for at least one cycle. `ack` while `pend` is 0 has no effect.
- R7: While a grant is held, `next_i` is 1. `next_ui` is 1 for a level-1 or non-maskable grant, and equals `mask_ui` for a level-0 grant. While nothing is held, `next_i`/`next_ui` equal `mask_i`/`mask_ui`.
- R8: A rising edge on `nmi_in` is captured in a latch that ignores both masks. The latch clears when its grant is acknowledged. A level held high yields exactly one grant per edge.
- R9: When `cfg_we` is 1 at an edge, `cfg_wdata` is written to level register `cfg_addr`. Bit b of register a is the level bit of source a*REG_W+b, where REG_W is 4 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_SRC | Synchronised maskable request lines |
| en | input | N_SRC | Per-source enable bits |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| mask_i | input | 1 | Processor primary mask flag |
| mask_ui | input | 1 | Processor secondary mask flag |
| ack | input | 1 | Grant taken strobe |
| cfg_we | input | 1 | Level register write enable |
| cfg_addr | input | AW | Level register index |
| cfg_wdata | input | REG_W | Level register write data |
| pend | output | 1 | A grant is held |
| pend_id | output | IDW | Granted source index (N_SRC = non-maskable) |
| next_i | output | 1 | Primary mask value to load on taking the grant |
| next_ui | output | 1 | Secondary mask value to load on taking the grant |

## Verification
A corrupted level bit shows on the very next grant. A source then either wins or loses against a neighbour in the wrong order, or gets through or is blocked under `mask_i`=1, `mask_ui`=0, and `next_ui` takes the wrong value. A stuck or lost non-maskable latch shows within two cycles of an edge, as a missing grant or as a second grant while the line stays high. A grant register that ignores or over-obeys `ack` shows one cycle later, as a changed `pend_id` or a `pend` that fails to drop.

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N_SRC = 8,
  parameter int REG_W = 4,
  localparam int N_REG = (N_SRC + REG_W - 1) / REG_W,
  localparam int AW    = (N_REG > 1) ? $clog2(N_REG) : 1,
  localparam int IDW   = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] en,
  input  logic             nmi_in,
  input  logic             mask_i,
  input  logic             mask_ui,
  input  logic             ack,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic             pend,
  output logic [IDW-1:0]   pend_id,
  output logic             next_i,
  output logic             next_ui
);
  localparam logic [IDW-1:0] NMI_ID = IDW'(N_SRC);

  logic [N_REG*REG_W-1:0] lvl_bank;
  logic [N_SRC-1:0]       lvl;
  logic                   nmi_d, nmi_lat;
  logic                   pend_q, hi_q;
  logic [IDW-1:0]         id_q;

  for (genvar r = 0; r < N_REG; r++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        lvl_bank[r*REG_W +: REG_W] <= '0;
      else if (cfg_we && cfg_addr == AW'(r))
        lvl_bank[r*REG_W +: REG_W] <= cfg_wdata;
    end
  end

  assign lvl = lvl_bank[N_SRC-1:0];

  wire [N_SRC-1:0] cand1 = req & en & lvl  & {N_SRC{~(mask_i & mask_ui)}};
  wire [N_SRC-1:0] cand0 = req & en & ~lvl & {N_SRC{~mask_i}};

  logic           win_any, win_hi;
  logic [IDW-1:0] win_id;

  always_comb begin
    win_any = 1'b0;
    win_hi  = 1'b0;
    win_id  = '0;
    for (int s = N_SRC - 1; s >= 0; s--)
      if (cand0[s]) begin
        win_any = 1'b1;
        win_id  = IDW'(s);
      end
    for (int s = N_SRC - 1; s >= 0; s--)
      if (cand1[s]) begin
        win_any = 1'b1;
        win_hi  = 1'b1;
        win_id  = IDW'(s);
      end
    if (nmi_lat) begin
      win_any = 1'b1;
      win_hi  = 1'b1;
      win_id  = NMI_ID;
    end
  end

  wire take = pend_q & ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_d   <= 1'b0;
      nmi_lat <= 1'b0;
    end else begin
      nmi_d   <= nmi_in;
      nmi_lat <= (nmi_in & ~nmi_d) | (nmi_lat & ~(take & (id_q == NMI_ID)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hi_q   <= 1'b0;
      id_q   <= '0;
    end else if (take) begin
      pend_q <= 1'b0;
    end else if (!pend_q && win_any) begin
      pend_q <= 1'b1;
      hi_q   <= win_hi;
      id_q   <= win_id;
    end
  end

  assign pend    = pend_q;
  assign pend_id = id_q;
  assign next_i  = pend_q | mask_i;
  assign next_ui = pend_q ? (hi_q | mask_ui) : mask_ui;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int N_SRC = 8,
  parameter int IDW   = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mask_i,
  input logic           mask_ui,
  input logic           ack,
  input logic           pend,
  input logic [IDW-1:0] pend_id,
  input logic           next_i,
  input logic           next_ui
);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !ack |=> pend && $stable(pend_id));
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && ack |=> !pend);
  // R5
  id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> pend_id <= IDW'(N_SRC));
  // R7
  mask_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> next_i);
  // R7
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> (next_i == mask_i) && (next_ui == mask_ui));
  // R3
  grant_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) && pend_id != IDW'(N_SRC) |-> $past(!mask_i || !mask_ui));
  // R4
  only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) && $past(mask_i && mask_ui) |-> pend_id == IDW'(N_SRC));
endmodule

bind irq_arb irq_arb_chk #(.N_SRC(N_SRC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .mask_ui(mask_ui), .ack(ack),
  .pend(pend), .pend_id(pend_id), .next_i(next_i), .next_ui(next_ui)
);

// File: tb/irq_arb_tb.sv
`timescale 1ns/1ps
module irq_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0, en = '0;
  logic       nmi_in = 1'b0, mask_i = 1'b0, mask_ui = 1'b0, ack = 1'b0;
  logic       cfg_we = 1'b0;
  logic [0:0] cfg_addr = '0;
  logic [3:0] cfg_wdata = '0;
  logic       pend, next_i, next_ui;
  logic [3:0] pend_id;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .en(en), .nmi_in(nmi_in),
    .mask_i(mask_i), .mask_ui(mask_ui), .ack(ack), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pend(pend),
    .pend_id(pend_id), .next_i(next_i), .next_ui(next_ui)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic take_and_clear();
    req = '0;
    ack = 1'b1;
    tick();
    ack = 1'b0;
    tick();
  endtask

  task automatic wr_lvl(input logic [0:0] a, input logic [3:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  // {req, en, i, ui, exp_pend, exp_id, exp_next_i, exp_next_ui}; sources 2,3 at level 1
  localparam logic [24:0] VEC [10] = '{
    {8'h0F, 8'hFF, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 1'b1},
    {8'h09, 8'hFF, 1'b0, 1'b0, 1'b1, 4'd3, 1'b1, 1'b1},
    {8'h03, 8'hFF, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 1'b0},
    {8'h8C, 8'hF3, 1'b0, 1'b0, 1'b1, 4'd7, 1'b1, 1'b0},
    {8'h01, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0},
    {8'h09, 8'hFF, 1'b1, 1'b0, 1'b1, 4'd3, 1'b1, 1'b1},
    {8'h0C, 8'hFF, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0},
    {8'h30, 8'hFF, 1'b0, 1'b1, 1'b1, 4'd4, 1'b1, 1'b1},
    {8'h08, 8'hFF, 1'b0, 1'b1, 1'b1, 4'd3, 1'b1, 1'b1},
    {8'h0C, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    en = 8'hFF;
    repeat (3) tick();
    chk("R1 pend in reset", pend, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 pend after reset", pend, 0);
    // R1: all levels 0, so masked by I even with UI clear
    req = 8'h0C; mask_i = 1'b1; mask_ui = 1'b0;
    tick();
    chk("R1 level bits reset", pend, 0);
    req = '0;
    tick();

    wr_lvl(1'b0, 4'b1100);
    for (int k = 0; k < 10; k++) begin
      logic [24:0] v;
      v = VEC[k];
      req = v[24:17]; en = v[16:9]; mask_i = v[8]; mask_ui = v[7];
      tick();
      chk($sformatf("R2,R3,R4,R5 vec%0d pend", k), pend, v[6]);
      if (v[6]) begin
        chk($sformatf("R5 vec%0d id", k), pend_id, v[5:2]);
        chk($sformatf("R7 vec%0d next_i", k), next_i, v[1]);
        chk($sformatf("R7 vec%0d next_ui", k), next_ui, v[0]);
      end
      take_and_clear();
      chk($sformatf("R6 vec%0d cleared", k), pend, 0);
    end
    en = 8'hFF;

    // R6 hold until ack
    mask_i = 1'b0; mask_ui = 1'b0;
    req = 8'h01;
    tick();
    chk("R6 grant id", pend_id, 0);
    req = '0;
    tick(); tick();
    chk("R6 held pend", pend, 1);
    chk("R6 held id", pend_id, 0);
    req = 8'h04;
    tick();
    chk("R6 no preempt", pend_id, 0);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R6 gap after ack", pend, 0);
    tick();
    chk("R6 regrant", pend_id, 2);
    chk("R7 level-1 ui", next_ui, 1);
    take_and_clear();
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk("R6 idle ack ignored", pend, 0);
    req = 8'h02;
    tick();
    chk("R6 grant after idle ack", pend_id, 1);
    take_and_clear();

    // R8 NMI through full mask
    mask_i = 1'b1; mask_ui = 1'b1;
    nmi_in = 1'b1;
    tick(); tick();
    chk("R8 nmi granted", pend, 1);
    chk("R8 nmi id", pend_id, 8);
    chk("R7 nmi next_ui", next_ui, 1);
    take_and_clear();
    tick();
    chk("R8 single grant per edge", pend, 0);
    nmi_in = 1'b0;
    tick();

    // R5 NMI beats level 1
    mask_i = 1'b0; mask_ui = 1'b0;
    nmi_in = 1'b1;
    tick();
    req = 8'h04;
    tick();
    chk("R5 nmi first", pend_id, 8);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    tick();
    chk("R8 latch cleared", pend_id, 2);
    take_and_clear();
    chk("R8 no repeat", pend, 0);
    nmi_in = 1'b0;
    tick();

    // R9 level register 1, bit 2 -> source 6
    wr_lvl(1'b1, 4'b0100);
    req = 8'h41;
    tick();
    chk("R9 source 6 promoted", pend_id, 6);
    take_and_clear();
    mask_i = 1'b1;
    req = 8'h40;
    tick();
    chk("R9 source 6 level 1 under I", pend_id, 6);
    take_and_clear();
    wr_lvl(1'b1, 4'b0000);
    req = 8'h40;
    tick();
    chk("R9 source 6 demoted", pend, 0);
    req = '0;
    tick();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule